// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers up to 63 level-sensitive interrupt request lines and picks one winner for the processor. Each source has a small control register that sets an interrupt level (1 to 7, where 0 means disabled) and a priority inside that level (0 to 7). Sources with indices 1 to 7 are hardwired. Source n always sits at level n, and its priority sits at the midpoint of that level. Sources from index 8 up are set through a plain register read/write port whose address is the source index.

The highest level among the pending, enabled sources is driven on a combinational level output for the processor. A registered copy of the winning source index follows one cycle later. When the processor acknowledges a given level, the block captures the best pending source at that level. It reports the level, a 4-bit priority code and a vector number equal to 64 plus the source index. If nothing is pending at the requested level, it returns a spurious vector.

Top module: `irq_level_ctrl`

## Requirements
- R1: A control register read returns level in bits 5:3 and priority in bits 2:0. Bits 7:6 always read 0, and address 0 reads 0.
- R2: Registers of sources 8 to 63 reset to 0 and take bits 5:0 of a write on the cycle after the write strobe.
- R3: Registers of sources 1 to 7 ignore writes and always read level = source index, priority = 0.
- R4: A source whose level is 0 never becomes pending and never wins arbitration or an acknowledge.
- R5: Among pending enabled sources, a higher level always wins. Within the same level, a higher priority wins (7 highest, 0 lowest).
- R6: A hardwired source ranks above programmed priorities 0 to 3 and below programmed priorities 4 to 7 of the same level.
- R7: A request input is registered into a pending bit one cycle after it is seen. The level output is combinational over the pending bits and is 0 when nothing enabled is pending.
- R8: The winning source index output is registered one cycle after the level output. It is 0 when nothing is pending.
- R9: An acknowledge strobe with a requested level captures the best pending source at that level into the report on the next cycle. The report gives its level, a priority code (0 to 7 for programmed sources, 8 for a hardwired source) and vector 64 + source index.
- R10: An acknowledge with no pending source at the requested level, including requested level 0, reports level 0, priority code 0 and vector 24. This is also the report's reset state.
- R11: Two enabled sources with equal level and priority resolve to the lower source index.
- R12: A pending bit clears on the cycle after its request input drops or its level is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 63 | Request lines, bit n is source n (indices 1..63) |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 6 | Control register address = source index |
| reg_wdata | input | 8 | Write data (bits 5:3 level, 2:0 priority) |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ipl | output | 3 | Level of the highest pending request, 0 if none |
| top_src | output | 6 | Registered index of the overall winner, 0 if none |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_level | output | 3 | Captured level of the acknowledged source |
| ack_pri | output | 4 | Captured priority code, 8 = hardwired midpoint |
| ack_vec | output | 8 | Captured vector number |

## Verification
The bench builds the block with its default parameters: 63 sources, 7 hardwired, vector base 64 and spurious vector 24. With these values the full index range is in reach, up to vector 127 for source 63, and the whole hardwired band from level 1 to level 7 can meet programmed sources at every level. Directed scenarios place hardwired sources against programmed priorities 3 and 4 of their own level, and set up equal-key ties. A long pseudo-random phase then mixes writes, request changes and acknowledges at every level, including level 0.

// File: rtl/irqc_pkg.sv
// Shared types and helpers for the leveled interrupt controller.
// Assumes 3-bit levels and 3-bit priorities; rank is a 4-bit scale on which
// programmed priority p sits at 2p and the hardwired midpoint sits at 7.
package irqc_pkg;

    localparam int LVL_W  = 3;
    localparam int PRI_W  = 3;
    localparam int RANK_W = PRI_W + 1;
    localparam int REG_W  = 8;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } ctl_t;

    // Map a source's priority to its position on the doubled rank scale.
    function automatic logic [RANK_W-1:0] rank_of(input logic fixed_src,
                                                  input logic [PRI_W-1:0] pri);
        return fixed_src ? RANK_W'(7) : {pri, 1'b0};
    endfunction

endpackage

// File: rtl/irqc_regfile.sv
// Control register bank: one level/priority register per source.
// Sources 1..FIXED_SRC are hardwired to level = index, priority 0 and
// ignore writes. Higher sources are flops cleared by reset.
// Assumes FIXED_SRC <= 7 so that the index fits the level field.
module irqc_regfile #(
    parameter int NUM_SRC   = 63,
    parameter int FIXED_SRC = 7,
    parameter int IDX_W     = $clog2(NUM_SRC + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  addr,
    input  logic [irqc_pkg::REG_W-1:0]        wdata,
    output logic [irqc_pkg::REG_W-1:0]        rdata,
    output irqc_pkg::ctl_t [NUM_SRC:1]        ctl_o
);
    import irqc_pkg::*;

    localparam int RSV_W = REG_W - LVL_W - PRI_W;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        if (s <= FIXED_SRC) begin : g_fixed
            assign ctl_o[s] = ctl_t'({LVL_W'(s), PRI_W'(0)});
        end else begin : g_prog
            ctl_t ctl_q;
            // Hold the programmed level/priority; load on an address match.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_q <= '0;
                end else if (wr_en && addr == IDX_W'(s)) begin
                    ctl_q <= ctl_t'(wdata[LVL_W+PRI_W-1:0]);
                end
            end
            assign ctl_o[s] = ctl_q;
        end
    end

    // Read mux: reserved bits and unmatched addresses return zero.
    always_comb begin
        rdata = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (addr == IDX_W'(s)) begin
                rdata = {RSV_W'(0), ctl_o[s]};
            end
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
// Combinational priority search over pending sources.
// Key = {level, rank}; a strictly greater key replaces the current best,
// so equal keys fall to the lower index. Level 0 sources never qualify.
// With filt_en set, only sources at level filt_lvl qualify.
module irqc_arbiter #(
    parameter int NUM_SRC   = 63,
    parameter int FIXED_SRC = 7,
    parameter int IDX_W     = $clog2(NUM_SRC + 1)
) (
    input  irqc_pkg::ctl_t [NUM_SRC:1]        ctl_i,
    input  logic [NUM_SRC:1]                  pend_i,
    input  logic                              filt_en,
    input  logic [irqc_pkg::LVL_W-1:0]        filt_lvl,
    output logic                              found,
    output logic [IDX_W-1:0]                  win_idx,
    output logic [irqc_pkg::LVL_W-1:0]        win_lvl,
    output logic [irqc_pkg::PRI_W-1:0]        win_pri,
    output logic                              win_fixed
);
    import irqc_pkg::*;

    localparam int KEY_W = LVL_W + RANK_W;

    logic [KEY_W-1:0] best_key;

    // Linear scan from the lowest index, keeping the strictly best key.
    always_comb begin
        logic [KEY_W-1:0] key;
        logic             elig;
        found     = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        win_pri   = '0;
        win_fixed = 1'b0;
        best_key  = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            key  = {ctl_i[s].lvl, rank_of(s <= FIXED_SRC, ctl_i[s].pri)};
            elig = pend_i[s] && (ctl_i[s].lvl != '0)
                   && (!filt_en || ctl_i[s].lvl == filt_lvl);
            if (elig && (!found || key > best_key)) begin
                found     = 1'b1;
                best_key  = key;
                win_idx   = IDX_W'(s);
                win_lvl   = ctl_i[s].lvl;
                win_pri   = ctl_i[s].pri;
                win_fixed = (s <= FIXED_SRC);
            end
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
// Leveled interrupt priority controller top.
// Registers request lines into pending bits (masked by enable), drives the
// winning level combinationally, registers the winning index, and captures
// an acknowledge report for a requested level. Requests are level-sensitive.
module irq_level_ctrl #(
    parameter int NUM_SRC   = 63,
    parameter int FIXED_SRC = 7,
    parameter int VEC_BASE  = 64,
    parameter int SPUR_VEC  = 24,
    parameter int IDX_W     = $clog2(NUM_SRC + 1),
    parameter int VEC_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC:1]             irq_req,
    input  logic                         reg_wr,
    input  logic [IDX_W-1:0]             reg_addr,
    input  logic [irqc_pkg::REG_W-1:0]   reg_wdata,
    output logic [irqc_pkg::REG_W-1:0]   reg_rdata,
    output logic [irqc_pkg::LVL_W-1:0]   ipl,
    output logic [IDX_W-1:0]             top_src,
    input  logic                         ack_stb,
    input  logic [irqc_pkg::LVL_W-1:0]   ack_lvl,
    output logic [irqc_pkg::LVL_W-1:0]   ack_level,
    output logic [irqc_pkg::CODE_W-1:0]  ack_pri,
    output logic [VEC_W-1:0]             ack_vec
);
    import irqc_pkg::*;

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(8);

    ctl_t [NUM_SRC:1]  ctl;
    logic [NUM_SRC:1]  enabled;
    logic [NUM_SRC:1]  pend_q;

    logic              t_found, a_found;
    logic [IDX_W-1:0]  t_idx, a_idx;
    logic [LVL_W-1:0]  t_lvl, a_lvl;
    logic [PRI_W-1:0]  t_pri, a_pri;
    logic              t_fixed, a_fixed;

    logic [IDX_W-1:0]  top_q;
    logic [LVL_W-1:0]  ack_level_q;
    logic [CODE_W-1:0] ack_pri_q;
    logic [VEC_W-1:0]  ack_vec_q;

    irqc_regfile #(
        .NUM_SRC   (NUM_SRC),
        .FIXED_SRC (FIXED_SRC),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl_o (ctl)
    );

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_en
        assign enabled[s] = (ctl[s].lvl != '0);
    end

    // Pending bits follow the request lines, masked by a non-zero level.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_req & enabled;
    end

    irqc_arbiter #(
        .NUM_SRC   (NUM_SRC),
        .FIXED_SRC (FIXED_SRC),
        .IDX_W     (IDX_W)
    ) u_arb_top (
        .ctl_i     (ctl),
        .pend_i    (pend_q),
        .filt_en   (1'b0),
        .filt_lvl  ('0),
        .found     (t_found),
        .win_idx   (t_idx),
        .win_lvl   (t_lvl),
        .win_pri   (t_pri),
        .win_fixed (t_fixed)
    );

    irqc_arbiter #(
        .NUM_SRC   (NUM_SRC),
        .FIXED_SRC (FIXED_SRC),
        .IDX_W     (IDX_W)
    ) u_arb_ack (
        .ctl_i     (ctl),
        .pend_i    (pend_q),
        .filt_en   (1'b1),
        .filt_lvl  (ack_lvl),
        .found     (a_found),
        .win_idx   (a_idx),
        .win_lvl   (a_lvl),
        .win_pri   (a_pri),
        .win_fixed (a_fixed)
    );

    assign ipl = t_found ? t_lvl : '0;

    // Register the overall winner one cycle behind the level output.
    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= t_found ? t_idx : '0;
    end

    // Capture the acknowledge report, or the spurious answer if none pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_level_q <= '0;
            ack_pri_q   <= '0;
            ack_vec_q   <= VEC_W'(SPUR_VEC);
        end else if (ack_stb) begin
            if (a_found) begin
                ack_level_q <= a_lvl;
                ack_pri_q   <= a_fixed ? MID_CODE : {1'b0, a_pri};
                ack_vec_q   <= VEC_W'(VEC_BASE) + VEC_W'(a_idx);
            end else begin
                ack_level_q <= '0;
                ack_pri_q   <= '0;
                ack_vec_q   <= VEC_W'(SPUR_VEC);
            end
        end
    end

    assign top_src   = top_q;
    assign ack_level = ack_level_q;
    assign ack_pri   = ack_pri_q;
    assign ack_vec   = ack_vec_q;

    // Only the overall winner's index and level are needed from this search.
    logic unused_top;
    assign unused_top = ^{t_pri, t_fixed};

endmodule

// File: rtl/irqc_checker.sv
// Property checker for irq_level_ctrl, attached with bind below.
module irqc_checker #(
    parameter int NUM_SRC   = 63,
    parameter int FIXED_SRC = 7,
    parameter int VEC_BASE  = 64,
    parameter int SPUR_VEC  = 24,
    parameter int IDX_W     = 6,
    parameter int VEC_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] reg_addr,
    input logic [7:0]       reg_rdata,
    input logic [NUM_SRC:1] pend_q,
    input logic [2:0]       ipl,
    input logic [IDX_W-1:0] top_src,
    input logic [2:0]       ack_level,
    input logic [3:0]       ack_pri,
    input logic [VEC_W-1:0] ack_vec
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:6] == 2'b00); // R1

    AST_FIXED_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= 1 && reg_addr <= IDX_W'(FIXED_SRC)) |->
        (reg_rdata[2:0] == 3'b000 && reg_rdata[5:3] == reg_addr[2:0])); // R3

    AST_IDLE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (ipl == 3'd0)); // R7

    AST_TOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl == 3'd0) |=> (top_src == '0)); // R8

    AST_TOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl != 3'd0) |=> (top_src != '0)); // R8

    AST_ACK_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_level != 3'd0) |->
        (ack_vec > VEC_W'(VEC_BASE) && ack_vec <= VEC_W'(VEC_BASE + NUM_SRC))); // R9

    AST_MID_IS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pri == 4'd8) |->
        (ack_vec <= VEC_W'(VEC_BASE + FIXED_SRC) && ack_level != 3'd0)); // R9

    AST_PRI_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pri <= 4'd8); // R9

    AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_level == 3'd0) |-> (ack_vec == VEC_W'(SPUR_VEC) && ack_pri == 4'd0)); // R10

endmodule

bind irq_level_ctrl irqc_checker #(
    .NUM_SRC   (NUM_SRC),
    .FIXED_SRC (FIXED_SRC),
    .VEC_BASE  (VEC_BASE),
    .SPUR_VEC  (SPUR_VEC),
    .IDX_W     (IDX_W),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pend_q    (pend_q),
    .ipl       (ipl),
    .top_src   (top_src),
    .ack_level (ack_level),
    .ack_pri   (ack_pri),
    .ack_vec   (ack_vec)
);

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
    localparam int N = 63;
    localparam int F = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N:1]  irq_req = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  ipl;
    logic [5:0]  top_src;
    logic        ack_stb = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic [2:0]  ack_level;
    logic [3:0]  ack_pri;
    logic [7:0]  ack_vec;

    always #4 clk = ~clk;

    irq_level_ctrl u_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ipl(ipl), .top_src(top_src),
        .ack_stb(ack_stb), .ack_lvl(ack_lvl),
        .ack_level(ack_level), .ack_pri(ack_pri), .ack_vec(ack_vec)
    );

    // ---------------- behavioural reference model ----------------
    int  m_lvl [0:N];
    int  m_pri [0:N];
    bit  m_pend[0:N];
    int  m_top, m_alvl, m_apri, m_avec;
    bit  started = 0;
    int  n_cmp = 0, n_bad = 0;
    string tag = "R2";

    function automatic int score(int s);
        return m_lvl[s] * 100 + ((s <= F) ? 35 : m_pri[s] * 10);
    endfunction

    // Best pending source; lf < 0 means any level. Returns 0 if none.
    function automatic int best(int lf);
        int b = 0;
        int bs = -1;
        for (int s = 1; s <= N; s++) begin
            if (m_pend[s] && m_lvl[s] != 0 && (lf < 0 || m_lvl[s] == lf)
                && score(s) > bs) begin
                bs = score(s);
                b = s;
            end
        end
        return b;
    endfunction

    function automatic int exp_rdata(int a);
        if (a < 1 || a > N) return 0;
        return m_lvl[a] * 8 + m_pri[a];
    endfunction

    initial begin
        for (int s = 0; s <= N; s++) begin
            m_lvl[s] = (s >= 1 && s <= F) ? s : 0;
            m_pri[s] = 0;
            m_pend[s] = 0;
        end
        m_top = 0; m_alvl = 0; m_apri = 0; m_avec = 24;
    end

    // Model update on each rising edge, from the inputs held since the last one.
    always @(posedge clk) begin
        int a;
        started = 1;
        if (!rst_n) begin
            for (int s = F + 1; s <= N; s++) begin
                m_lvl[s] = 0; m_pri[s] = 0;
            end
            for (int s = 0; s <= N; s++) m_pend[s] = 0;
            m_top = 0; m_alvl = 0; m_apri = 0; m_avec = 24;
        end else begin
            if (ack_stb) begin
                a = best(int'(ack_lvl));
                if (a != 0) begin
                    m_alvl = m_lvl[a];
                    m_apri = (a <= F) ? 8 : m_pri[a];
                    m_avec = 64 + a;
                end else begin
                    m_alvl = 0; m_apri = 0; m_avec = 24;
                end
            end
            m_top = best(-1);
            for (int s = 1; s <= N; s++) m_pend[s] = irq_req[s] && (m_lvl[s] != 0);
            if (reg_wr && reg_addr > F && reg_addr <= N) begin
                m_lvl[reg_addr] = int'(reg_wdata[5:3]);
                m_pri[reg_addr] = int'(reg_wdata[2:0]);
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        int b;
        if (started) begin
            b = best(-1);
            cmp("reg_rdata", int'(reg_rdata), exp_rdata(int'(reg_addr)));
            cmp("ipl", int'(ipl), (b != 0) ? m_lvl[b] : 0);
            cmp("top_src", int'(top_src), m_top);
            cmp("ack_level", int'(ack_level), m_alvl);
            cmp("ack_pri", int'(ack_pri), m_apri);
            cmp("ack_vec", int'(ack_vec), m_avec);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        ack_stb = 1'b0;
    endtask

    task automatic wr(int a, int lvl, int pri);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(lvl * 8 + pri) | 8'hC0;
        step();
    endtask

    task automatic rd(int a);
        reg_addr = 6'(a);
        step();
    endtask

    task automatic ack(int lvl);
        ack_stb = 1'b1; ack_lvl = 3'(lvl);
        step();
        step();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int seed = 32'h1D5C_0A17;
        // R2 / R10: reset state of registers and the acknowledge report
        tag = "R2";
        repeat (3) step();
        rst_n = 1'b1;
        rd(8); rd(63); rd(0);
        tag = "R10"; step();
        // R1: readback layout, reserved bits dropped on write
        tag = "R1";
        wr(8, 7, 7); rd(8); wr(33, 2, 5); rd(33); rd(0);
        // R3: hardwired registers ignore writes
        tag = "R3";
        for (int s = 1; s <= F; s++) begin
            wr(s, 0, 7); rd(s);
        end
        // R4: disabled source never pends
        tag = "R4";
        wr(10, 0, 6); irq_req[10] = 1'b1; step(); step(); ack(0);
        // R5: level beats priority, then priority within a level
        tag = "R5";
        wr(10, 3, 2); wr(20, 3, 5); wr(30, 2, 7);
        irq_req[20] = 1'b1; irq_req[30] = 1'b1; step(); step();
        ack(3); ack(2);
        // R6: hardwired source 3 (level 3) between priorities 3 and 4
        tag = "R6";
        irq_req[3] = 1'b1; step(); step(); ack(3);
        wr(20, 3, 3); step(); step(); ack(3);
        wr(20, 3, 4); step(); ack(3);
        // R11: equal keys go to the lower index
        tag = "R11";
        wr(40, 5, 4); wr(41, 5, 4); irq_req[41] = 1'b1; irq_req[40] = 1'b1;
        step(); step(); ack(5);
        // R12: dropping a request or disabling a source clears pending
        tag = "R12";
        irq_req[40] = 1'b0; step(); step(); ack(5);
        wr(41, 0, 4); step(); step(); ack(5);
        // R9 / R10: acknowledge at a level with nothing pending, and top source
        tag = "R9";
        wr(63, 7, 1); irq_req[63] = 1'b1; step(); ack(7);
        tag = "R10"; ack(6); ack(0);
        // R7 / R8: clear all and watch the outputs settle
        tag = "R7";
        irq_req = '0; step(); step(); step();
        // Mixed pseudo-random traffic
        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            case ((seed >>> 8) & 3)
                0: begin
                    reg_wr = 1'b1;
                    reg_addr = 6'((seed >>> 12) & 63);
                    reg_wdata = 8'((seed >>> 20) & 255);
                end
                1: irq_req[((seed >>> 12) % N + N) % N + 1] ^= 1'b1;
                2: begin
                    ack_stb = 1'b1;
                    ack_lvl = 3'((seed >>> 14) & 7);
                end
                default: reg_addr = 6'((seed >>> 16) & 63);
            endcase
            step();
        end
        step(); step();
        finish_run();
    end
endmodule